// File: doc/BRIEF.md
# SDRAM Command Tracker

This block watches the control pins of a single-data-rate SDRAM on every rising clock edge and turns them into one decoded command. It also keeps a model of what the four banks are doing. Each bank is either idle or open, and for an open bank the block keeps the 13-bit row that was opened. A bank with a pending automatic close is counted as still open until the close completes. The block can sit beside a memory controller as a protocol monitor, or it can act as the front end of a memory model.

The block raises a one-cycle error strobe when a command does not fit the state of the banks. Illegal commands include:
- opening a bank that is already open;
- reading from or writing to a closed bank, or to a bank that is already closing;
- refreshing, or loading the mode register, while any bank is open.

An illegal command changes no state. Address bit 10 has two meanings. On a read or write it asks for an automatic close once the burst ends, and that close is timed from a burst-length input. On a precharge it widens the close from one bank to all four.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: When chip select (`csN`) is high at a clock edge, the command is deselect. The block reports it as no-operation, sets no error and changes no bank state.
- R2: With `csN` low, the pattern {rasN,casN,weN} is decoded as follows, and `cmdOut` reports it in the next cycle:
  - 111 is NOP (code 0).
  - 011 is ACTIVATE (code 1).
  - 101 is READ (code 2).
  - 100 is WRITE (code 3).
  - 010 is PRECHARGE (code 4).
  - 001 with `cke` high is REFRESH (code 5). With `cke` low the same pattern is reported as NOP.
  - 000 is MODE-SET (code 6).
  - 110 is BURST-STOP (code 7), which has no effect on bank state.
- R3: ACTIVATE on an idle bank (selected by `ba`) opens that bank and stores `rowAddr` as its open row. ACTIVATE on an open bank raises the error and leaves the bank and its row unchanged.
- R4: READ or WRITE to a bank that is idle, or that has a pending automatic close, raises the error and changes no state.
- R5: A legal READ or WRITE with `a10` high keeps the bank open. The bank becomes idle N clock edges after the command edge, where N is `burstLen`, with 0 treated as 1. A legal READ or WRITE with `a10` low leaves the bank open.
- R6: PRECHARGE with `a10` low closes only the addressed bank and cancels any pending automatic close on it. It is legal on an idle bank.
- R7: PRECHARGE with `a10` high closes all four banks. It is never an error.
- R8: REFRESH and MODE-SET are legal only while every bank is idle. Otherwise they raise the error. Neither one changes bank state.
- R9: `cmdOut` and `errPulse` are registered. They describe the command sampled at the previous edge, and `errPulse` is high for exactly the cycles that follow illegal commands.
- R10: While reset is active, all banks are idle, all open rows are 0, `cmdOut` is NOP and `errPulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins sampled on rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable; qualifies refresh |
| a10 | input | 1 | Auto-close / all-bank qualifier |
| ba | input | 2 | Bank select |
| rowAddr | input | 13 | Row address for ACTIVATE |
| burstLen | input | 4 | Burst length used for auto-close timing |
| cmdOut | output | 3 | Decoded command of previous edge |
| errPulse | output | 1 | Illegal-command strobe |
| bankActive | output | 4 | One bit per bank, 1 = open |
| openRow | output | 52 | Open rows, bank i in bits [13i+12:13i] |

## Verification
The decoded command and the error strobe each appear one cycle after the edge that sampled the pins. Bank status and open rows change at that same edge, so all of them can be read at the next falling edge. An automatic close shows `bankActive` dropping `burstLen` edges after the command edge. The bench drives the pins at the falling edge and updates its reference model just after the rising edge. At the following falling edge it compares every output with the model, so each comparison lands exactly one register stage after its stimulus.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BA_W      = $clog2(NUM_BANKS);
  localparam int ROW_W     = 13;
  localparam int BL_W      = 4;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6,
    CMD_BST = 3'd7
  } cmd_e;

  typedef struct packed {
    logic [NUM_BANKS-1:0] openStb;
    logic [NUM_BANKS-1:0] closeStb;
    logic [NUM_BANKS-1:0] apStb;
  } bank_strobe_t;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
(
  input  logic csN,
  input  logic rasN,
  input  logic casN,
  input  logic weN,
  input  logic cke,
  output cmd_e cmd
);
  always_comb begin
    if (csN) begin
      cmd = CMD_NOP;
    end else begin
      unique case ({rasN, casN, weN})
        3'b111: cmd = CMD_NOP;
        3'b011: cmd = CMD_ACT;
        3'b101: cmd = CMD_RD;
        3'b100: cmd = CMD_WR;
        3'b010: cmd = CMD_PRE;
        3'b001: cmd = cke ? CMD_REF : CMD_NOP;
        3'b000: cmd = CMD_MRS;
        default: cmd = CMD_BST;
      endcase
    end
  end
endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  cmd_e                 cmd,
  input  logic [BA_W-1:0]      ba,
  input  logic                 a10,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic [NUM_BANKS-1:0] bankPend,
  output bank_strobe_t         stb,
  output cmd_e                 cmdOut,
  output logic                 errPulse
);
  logic [NUM_BANKS-1:0] selMask;
  logic                 illegal;
  logic                 anyOpen;

  assign selMask = NUM_BANKS'(1) << ba;
  assign anyOpen = |bankOpen;

  always_comb begin
    stb     = '0;
    illegal = 1'b0;
    unique case (cmd)
      CMD_ACT: begin
        if (bankOpen[ba]) illegal = 1'b1;
        else              stb.openStb = selMask;
      end
      CMD_RD, CMD_WR: begin
        if (!bankOpen[ba] || bankPend[ba]) illegal = 1'b1;
        else if (a10)                      stb.apStb = selMask;
      end
      CMD_PRE: stb.closeStb = a10 ? '1 : selMask;
      CMD_REF, CMD_MRS: illegal = anyOpen;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdOut   <= CMD_NOP;
      errPulse <= 1'b0;
    end else begin
      cmdOut   <= cmd;
      errPulse <= illegal;
    end
  end
endmodule

// File: rtl/sdram_bank_dp.sv
module sdram_bank_dp
  import sdram_cmd_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  bank_strobe_t               stb,
  input  logic [ROW_W-1:0]           rowIn,
  input  logic [BL_W-1:0]            burstLen,
  output logic [NUM_BANKS-1:0]       bankOpen,
  output logic [NUM_BANKS-1:0]       bankPend,
  output logic [NUM_BANKS*ROW_W-1:0] rowFlat
);
  logic [BL_W-1:0] blEff;
  assign blEff = (burstLen == '0) ? BL_W'(1) : burstLen;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             isOpen;
    logic [ROW_W-1:0] rowReg;
    logic [BL_W-1:0]  apCnt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        isOpen <= 1'b0;
        rowReg <= '0;
        apCnt  <= '0;
      end else if (stb.closeStb[b]) begin
        isOpen <= 1'b0;
        apCnt  <= '0;
      end else if (stb.openStb[b]) begin
        isOpen <= 1'b1;
        rowReg <= rowIn;
      end else if (stb.apStb[b]) begin
        apCnt  <= blEff;
      end else if (apCnt == BL_W'(1)) begin
        isOpen <= 1'b0;
        apCnt  <= '0;
      end else if (apCnt != '0) begin
        apCnt  <= apCnt - BL_W'(1);
      end
    end

    assign bankOpen[b] = isOpen;
    assign bankPend[b] = (apCnt != '0);
    assign rowFlat[b*ROW_W +: ROW_W] = rowReg;
  end
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_cmd_pkg::*;
#(
  parameter int ROW_BITS = ROW_W,
  parameter int BANKS    = NUM_BANKS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      csN,
  input  logic                      rasN,
  input  logic                      casN,
  input  logic                      weN,
  input  logic                      cke,
  input  logic                      a10,
  input  logic [BA_W-1:0]           ba,
  input  logic [ROW_BITS-1:0]       rowAddr,
  input  logic [BL_W-1:0]           burstLen,
  output logic [2:0]                cmdOut,
  output logic                      errPulse,
  output logic [BANKS-1:0]          bankActive,
  output logic [BANKS*ROW_BITS-1:0] openRow
);
  cmd_e                 decCmd;
  cmd_e                 regCmd;
  bank_strobe_t         stb;
  logic [NUM_BANKS-1:0] bankPend;

  sdram_cmd_decode u_dec (
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .cke(cke), .cmd(decCmd)
  );

  sdram_cmd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd(decCmd), .ba(ba), .a10(a10),
    .bankOpen(bankActive), .bankPend(bankPend), .stb(stb),
    .cmdOut(regCmd), .errPulse(errPulse)
  );

  sdram_bank_dp u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .rowIn(rowAddr), .burstLen(burstLen),
    .bankOpen(bankActive), .bankPend(bankPend), .rowFlat(openRow)
  );

  assign cmdOut = regCmd;
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk
  import sdram_cmd_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       csN,
  input logic                       a10,
  input logic [BA_W-1:0]            ba,
  input logic [2:0]                 cmdOut,
  input logic                       errPulse,
  input logic [NUM_BANKS-1:0]       bankActive,
  input logic [NUM_BANKS*ROW_W-1:0] openRow
);
  AST_DESEL_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(csN) |-> (cmdOut == 3'd0 && !errPulse)); // R1

  AST_ACT_OPENS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdOut == 3'd1 && !errPulse) |-> bankActive[$past(ba)]); // R3

  AST_ERR_KEEPS_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
    errPulse |-> $stable(openRow)); // R4

  AST_PREA_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdOut == 3'd4 && $past(a10)) |-> (bankActive == '0 && !errPulse)); // R7

  AST_REF_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdOut == 3'd5 && !errPulse) |-> ($past(bankActive) == '0)); // R8
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csN(csN), .a10(a10), .ba(ba),
  .cmdOut(cmdOut), .errPulse(errPulse), .bankActive(bankActive), .openRow(openRow)
);

// File: tb/sdram_cmd_tracker_tb.sv
module sdram_cmd_tracker_tb;
  localparam int NB = 4;
  localparam int RW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, cke = 1'b1, a10 = 1'b0;
  logic [1:0] ba = '0;
  logic [RW-1:0] rowAddr = '0;
  logic [3:0] burstLen = 4'd4;
  logic [2:0] cmdOut;
  logic errPulse;
  logic [NB-1:0] bankActive;
  logic [NB*RW-1:0] openRow;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  bit          mAct [NB];
  logic [RW-1:0] mRow [NB];
  int          mCnt [NB];
  logic [2:0]  expCmd = 3'd0;
  bit          expErr = 0;
  string       lastTag = "R10";

  always #2.5 clk = ~clk;

  sdram_cmd_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .a10(a10), .ba(ba), .rowAddr(rowAddr), .burstLen(burstLen),
    .cmdOut(cmdOut), .errPulse(errPulse), .bankActive(bankActive), .openRow(openRow)
  );

  function automatic logic [2:0] benchDecode(logic c, logic r, logic ca, logic w, logic k);
    if (c) return 3'd0;
    case ({r, ca, w})
      3'b111: return 3'd0;
      3'b011: return 3'd1;
      3'b101: return 3'd2;
      3'b100: return 3'd3;
      3'b010: return 3'd4;
      3'b001: return k ? 3'd5 : 3'd0;
      3'b000: return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

  function automatic bit anyModelOpen();
    for (int i = 0; i < NB; i++) if (mAct[i]) return 1;
    return 0;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    logic [NB-1:0] ea;
    logic [NB*RW-1:0] er;
    for (int i = 0; i < NB; i++) begin
      ea[i] = mAct[i];
      er[i*RW +: RW] = mRow[i];
    end
    chk(cmdOut == expCmd, "R2", "cmdOut", 64'(cmdOut), 64'(expCmd));
    chk(errPulse == expErr, "R9", "errPulse", 64'(errPulse), 64'(expErr));
    chk(bankActive == ea, lastTag, "bankActive", 64'(bankActive), 64'(ea));
    chk(openRow == er, lastTag, "openRow", 64'(openRow), 64'(er));
  endtask

  // applies one clock edge to the model with the pins driven before it
  task automatic modelEdge();
    logic [2:0] c;
    int b;
    int bl;
    bit ill;
    bit clo [NB];
    bit opn [NB];
    bit apl [NB];
    c = benchDecode(csN, rasN, casN, weN, cke);
    b = int'(ba);
    bl = (burstLen == 0) ? 1 : int'(burstLen);
    ill = 0;
    for (int i = 0; i < NB; i++) begin clo[i] = 0; opn[i] = 0; apl[i] = 0; end
    lastTag = csN ? "R1" : "R2";
    case (c)
      3'd1: begin lastTag = "R3"; if (mAct[b]) ill = 1; else opn[b] = 1; end
      3'd2, 3'd3: begin
        if (!mAct[b] || mCnt[b] != 0) begin ill = 1; lastTag = "R4"; end
        else if (a10) begin apl[b] = 1; lastTag = "R5"; end
      end
      3'd4: begin
        if (a10) begin lastTag = "R7"; for (int i = 0; i < NB; i++) clo[i] = 1; end
        else begin lastTag = "R6"; clo[b] = 1; end
      end
      3'd5, 3'd6: begin lastTag = "R8"; ill = anyModelOpen(); end
      default: ;
    endcase
    for (int i = 0; i < NB; i++) begin
      if (clo[i]) begin mAct[i] = 0; mCnt[i] = 0; end
      else if (opn[i]) begin mAct[i] = 1; mRow[i] = rowAddr; end
      else if (apl[i]) mCnt[i] = bl;
      else if (mCnt[i] == 1) begin mAct[i] = 0; mCnt[i] = 0; lastTag = "R5"; end
      else if (mCnt[i] != 0) mCnt[i]--;
    end
    expCmd = c;
    expErr = ill;
  endtask

  // op: 0 nop 1 act 2 rd 3 wr 4 pre 5 ref 6 mrs 7 bst 8 deselect
  task automatic cycle(int op, int bk, bit q10, logic [RW-1:0] row, bit k);
    @(negedge clk);
    compareAll();
    csN = (op == 8);
    case (op)
      1: {rasN, casN, weN} = 3'b011;
      2: {rasN, casN, weN} = 3'b101;
      3: {rasN, casN, weN} = 3'b100;
      4: {rasN, casN, weN} = 3'b010;
      5: {rasN, casN, weN} = 3'b001;
      6: {rasN, casN, weN} = 3'b000;
      7: {rasN, casN, weN} = 3'b110;
      8: {rasN, casN, weN} = 3'b011;
      default: {rasN, casN, weN} = 3'b111;
    endcase
    ba = 2'(bk);
    a10 = q10;
    rowAddr = row;
    cke = k;
    @(posedge clk);
    #1;
    modelEdge();
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin mAct[i] = 0; mRow[i] = '0; mCnt[i] = 0; end
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk(cmdOut == 3'd0 && !errPulse, "R10", "cmd/err in reset", 64'({cmdOut, errPulse}), 64'(0));
    chk(bankActive == '0 && openRow == '0, "R10", "banks in reset", 64'(bankActive), 64'(0));
    rst_n = 1'b1;

    // directed corners
    cycle(1, 0, 0, 13'h1ABC, 1);          // R3 open bank 0
    cycle(1, 0, 0, 13'h0555, 1);          // R3 reopen -> error
    cycle(2, 1, 0, 13'h0, 1);             // R4 read idle bank
    burstLen = 4'd3;
    cycle(3, 0, 1, 13'h0, 1);             // R5 write with auto-close
    cycle(2, 0, 0, 13'h0, 1);             // R4 read while closing
    cycle(0, 0, 0, 13'h0, 1);
    cycle(0, 0, 0, 13'h0, 1);
    cycle(5, 0, 0, 13'h0, 0);             // R2 refresh pattern, cke low -> NOP
    cycle(5, 0, 0, 13'h0, 1);             // R8 refresh with all idle
    cycle(1, 2, 0, 13'h1FFF, 1);
    cycle(6, 0, 0, 13'h0, 1);             // R8 mode-set while open -> error
    cycle(5, 0, 0, 13'h0, 1);             // R8 refresh while open -> error
    cycle(8, 3, 0, 13'h0123, 1);          // R1 deselect with ACT pattern
    cycle(7, 2, 0, 13'h0, 1);             // R2 burst stop
    burstLen = 4'd0;
    cycle(2, 2, 1, 13'h0, 1);             // R5 burstLen 0 acts as 1
    cycle(0, 0, 0, 13'h0, 1);
    cycle(1, 1, 0, 13'h0AAA, 1);
    burstLen = 4'd8;
    cycle(3, 1, 1, 13'h0, 1);
    cycle(4, 1, 0, 13'h0, 1);             // R6 precharge cancels auto-close
    cycle(4, 3, 0, 13'h0, 1);             // R6 precharge idle bank, no error
    cycle(1, 0, 0, 13'h0011, 1);
    cycle(1, 3, 0, 13'h0022, 1);
    cycle(4, 0, 1, 13'h0, 1);             // R7 close all
    cycle(6, 0, 0, 13'h0, 1);             // R8 mode-set legal

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int sel;
      int op;
      sel = int'($urandom_range(0, 19));
      if (sel < 5) op = 1;
      else if (sel < 9) op = 2;
      else if (sel < 12) op = 3;
      else if (sel < 14) op = 4;
      else if (sel < 15) op = 5;
      else if (sel < 16) op = 6;
      else if (sel < 17) op = 7;
      else if (sel < 18) op = 8;
      else op = 0;
      if ($urandom_range(0, 31) == 0) burstLen = 4'($urandom_range(0, 9));
      cycle(op, int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
            RW'($urandom), ($urandom_range(0, 7) != 0));
    end
    @(negedge clk);
    compareAll();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule